// File: doc/BRIEF.md
# Rate-Adjustable Cycle-to-Nanosecond Timecounter

This block turns a free-running 64-bit cycle count, supplied from outside, into a 64-bit time in nanoseconds. Each count nominally stands for 8 ns, which matches a 125 MHz counter clock. The conversion multiplies the cycles elapsed since a stored reference point by a 32-bit fixed-point multiplier. It then drops 28 fractional bits and adds the result to a stored base time. The fraction dropped at each fold is kept and added back in at the next fold, so truncation error never builds up.

A host drives five request lines to operate the block. It can take a snapshot of the time, load an absolute time, shift the time by a signed offset, retune the rate from a signed scaled-ppm value, or restart the counter with a new initial time. Any rate change first folds the time elapsed so far into the base at the old multiplier, so the time curve stays continuous. A refresh timer folds the time on its own whenever no fold has happened for a set number of cycles. This keeps the elapsed-cycle product from growing without bound. The refresh never competes with a host operation.

Top module: `tc_timecounter`

## Requirements
- R1: `now_ns` equals base + ((cnt_in − reference) × multiplier + carried fraction) >> 28, with the cycle difference taken modulo 2^64 so a counter wrap is handled. After `rst_n` the base is 0, the reference is 0 and the multiplier is 0x8000_0000, so each count adds exactly 8 ns.
- R2: A granted snapshot (request bit 0) loads `snap_ns` with the `now_ns` of its grant cycle. It raises `snap_valid` for the following cycle only, and folds the elapsed time into the base without changing `now_ns`.
- R3: A granted time load (request bit 1) makes `now_ns` equal `op_data` on the next cycle, at an unchanged `cnt_in`, with the carried fraction cleared.
- R4: A granted offset (request bit 2) adds `op_data`, read as a two's-complement value, to the time. It leaves the multiplier unchanged.
- R5: A granted rate change (request bit 3) reads `op_data[31:0]` as a signed scaled-ppm value p. It sets `rate_mult` to 0x8000_0000 + (p × 512 / 15625), with the quotient truncated toward zero. Time elapsed before the change is folded at the old multiplier, so `now_ns` does not move at the grant.
- R6: A p beyond ±2,097,152,000 is clamped to that limit, giving a multiplier between 0x7BE7_6C8C and 0x8418_9374. A clamp sets `rate_sat`, which stays set until `rst_n`.
- R7: The fraction below 1 ns is carried across folds. For example, at multiplier 0x8418_9374, twenty single-count snapshots give 165 ns and not 160 ns.
- R8: At most one request is granted per cycle, on `host_gnt` using the same bit positions as `host_req`. Priority from highest to lowest is restart (bit 4), snapshot (0), load (1), offset (2), rate (3).
- R9: A granted restart (request bit 4) drives `cnt_clear` high in its grant cycle. It sets the reference to count 0 and the time to `op_data`, so `now_ns` equals `op_data` once the counter reads 0.
- R10: `refresh_fire` rises when REFRESH_CYCLES clock edges have passed since the last snapshot, load, rate change, restart or refresh. It stays low while any request is held and fires in the first cycle with no request. It folds without changing `now_ns`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_in | input | 64 | Current free-running cycle count |
| host_req | input | 5 | Operation requests: 0 snapshot, 1 load, 2 offset, 3 rate, 4 restart |
| op_data | input | 64 | Operand: time, signed offset, scaled ppm in [31:0], or restart time |
| host_gnt | output | 5 | One-hot grant, same bit positions as `host_req` |
| cnt_clear | output | 1 | Clears the external counter at the next edge |
| now_ns | output | 64 | Current time in nanoseconds |
| snap_ns | output | 64 | Time captured by the last snapshot |
| snap_valid | output | 1 | One-cycle strobe after a snapshot |
| rate_mult | output | 32 | Active fixed-point multiplier |
| rate_sat | output | 1 | Sticky flag for a clamped rate request |
| refresh_fire | output | 1 | Internal refresh fold taking place this cycle |

## Verification
The refresh fold and a host request can fall due in the same cycle. The bench provokes this by holding an offset request across the cycle in which the refresh timer expires. It checks that `refresh_fire` stays low for the whole hold, then rises in the first idle cycle and drops once the fold restarts the timer. A second contention is between several host requests in one cycle. The bench raises pairs of request bits together and judges the one-hot grant, and then the resulting time, against the fixed priority order.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int OP_N    = 5;
  localparam int OP_READ = 0;
  localparam int OP_SET  = 1;
  localparam int OP_ADJ  = 2;
  localparam int OP_RATE = 3;
  localparam int OP_RST  = 4;

  typedef logic [OP_N-1:0] op_vec_t;

  // grant order, first entry wins
  localparam int PRIO [OP_N] = '{OP_RST, OP_READ, OP_SET, OP_ADJ, OP_RATE};

  localparam logic signed [31:0] PPM_LIMIT = 32'sd2097152000;
  localparam longint RATE_NUM = 512;
  localparam longint RATE_DEN = 15625;

  function automatic op_vec_t pick_grant(input op_vec_t r);
    op_vec_t g;
    g = '0;
    for (int i = OP_N - 1; i >= 0; i--) begin
      if (r[PRIO[i]]) begin
        g = '0;
        g[PRIO[i]] = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic logic signed [31:0] ppm_clamp(input logic signed [31:0] p);
    if (p > PPM_LIMIT) return PPM_LIMIT;
    if (p < -PPM_LIMIT) return -PPM_LIMIT;
    return p;
  endfunction

  // signed scaled-ppm to multiplier offset, quotient truncated toward zero
  function automatic longint ppm_offset(input logic signed [31:0] p);
    longint w;
    w = longint'(p);
    return (w * RATE_NUM) / RATE_DEN;
  endfunction

endpackage

// File: rtl/tc_arbiter.sv
module tc_arbiter
  import tc_pkg::*;
(
  input  op_vec_t host_req,
  input  logic    refresh_due,
  output op_vec_t host_gnt,
  output logic    refresh_fire
);
  assign host_gnt     = pick_grant(host_req);
  assign refresh_fire = refresh_due && (host_req == '0);
endmodule

// File: rtl/tc_refresh_timer.sv
module tc_refresh_timer #(
  parameter longint unsigned LIMIT = 64'd7_500_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic due
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] tmr_q;

  assign due = (tmr_q == TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)       tmr_q <= '0;
    else if (restart) tmr_q <= '0;
    else if (!due)    tmr_q <= tmr_q + TW'(1);
  end
endmodule

// File: rtl/tc_rate_conv.sv
module tc_rate_conv #(
  parameter int              MULT_W   = 32,
  parameter logic [MULT_W-1:0] NOM_MULT = '0
) (
  input  logic [31:0]       ppm_raw,
  output logic [MULT_W-1:0] mult_new,
  output logic              clamped
);
  logic signed [31:0] ppm_lim;

  assign ppm_lim  = tc_pkg::ppm_clamp(ppm_raw);
  assign clamped  = (ppm_lim != $signed(ppm_raw));
  assign mult_new = MULT_W'(longint'({1'b0, NOM_MULT}) + tc_pkg::ppm_offset(ppm_lim));
endmodule

// File: rtl/tc_fold.sv
module tc_fold #(
  parameter int CNT_W  = 64,
  parameter int NS_W   = 64,
  parameter int MULT_W = 32,
  parameter int SHIFT  = 28
) (
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [CNT_W-1:0]  cnt_last,
  input  logic [NS_W-1:0]   base_ns,
  input  logic [SHIFT-1:0]  frac,
  input  logic [MULT_W-1:0] mult,
  output logic [NS_W-1:0]   now_ns,
  output logic [SHIFT-1:0]  frac_next
);
  localparam int PW = NS_W + SHIFT;

  logic [CNT_W-1:0] delta;
  logic [PW-1:0]    prod;

  assign delta     = cnt_in - cnt_last;
  assign prod      = PW'(delta) * PW'(mult) + PW'(frac);
  assign frac_next = prod[SHIFT-1:0];
  assign now_ns    = base_ns + prod[PW-1:SHIFT];
endmodule

// File: rtl/tc_timecounter.sv
module tc_timecounter
  import tc_pkg::*;
#(
  parameter int              CNT_W          = 64,
  parameter int              NS_W           = 64,
  parameter int              MULT_W         = 32,
  parameter int              SHIFT          = 28,
  parameter int              TICK_NS        = 8,
  parameter longint unsigned REFRESH_CYCLES = 64'd7_500_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [OP_N-1:0]   host_req,
  input  logic [NS_W-1:0]   op_data,
  output logic [OP_N-1:0]   host_gnt,
  output logic              cnt_clear,
  output logic [NS_W-1:0]   now_ns,
  output logic [NS_W-1:0]   snap_ns,
  output logic              snap_valid,
  output logic [MULT_W-1:0] rate_mult,
  output logic              rate_sat,
  output logic              refresh_fire
);
  localparam logic [MULT_W-1:0] NOM_MULT = MULT_W'(longint'(TICK_NS) << SHIFT);

  logic [NS_W-1:0]   base_q;
  logic [CNT_W-1:0]  last_q;
  logic [SHIFT-1:0]  frac_q;
  logic [MULT_W-1:0] mult_q;
  logic              sat_q;
  logic [NS_W-1:0]   snap_q;
  logic              snap_v_q;

  op_vec_t           gnt;
  logic              refresh_due;
  logic              fold_ev;
  logic              timer_restart;
  logic [SHIFT-1:0]  frac_next;
  logic [MULT_W-1:0] mult_new;
  logic              rate_clamped;

  tc_arbiter u_arb (
    .host_req     (host_req),
    .refresh_due  (refresh_due),
    .host_gnt     (gnt),
    .refresh_fire (refresh_fire)
  );

  tc_refresh_timer #(.LIMIT(REFRESH_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (timer_restart),
    .due     (refresh_due)
  );

  tc_rate_conv #(.MULT_W(MULT_W), .NOM_MULT(NOM_MULT)) u_rate (
    .ppm_raw  (op_data[31:0]),
    .mult_new (mult_new),
    .clamped  (rate_clamped)
  );

  tc_fold #(.CNT_W(CNT_W), .NS_W(NS_W), .MULT_W(MULT_W), .SHIFT(SHIFT)) u_fold (
    .cnt_in    (cnt_in),
    .cnt_last  (last_q),
    .base_ns   (base_q),
    .frac      (frac_q),
    .mult      (mult_q),
    .now_ns    (now_ns),
    .frac_next (frac_next)
  );

  // events that move the reference point
  assign fold_ev       = gnt[OP_READ] | gnt[OP_RATE] | refresh_fire;
  assign timer_restart = fold_ev | gnt[OP_SET] | gnt[OP_RST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      last_q   <= '0;
      frac_q   <= '0;
      mult_q   <= NOM_MULT;
      sat_q    <= 1'b0;
      snap_q   <= '0;
      snap_v_q <= 1'b0;
    end else begin
      snap_v_q <= gnt[OP_READ];
      if (gnt[OP_READ]) snap_q <= now_ns;

      if (gnt[OP_RST]) begin
        base_q <= op_data;
        frac_q <= '0;
        last_q <= '0;
      end else if (gnt[OP_SET]) begin
        base_q <= op_data;
        frac_q <= '0;
        last_q <= cnt_in;
      end else if (gnt[OP_ADJ]) begin
        base_q <= base_q + op_data;
      end else if (fold_ev) begin
        base_q <= now_ns;
        frac_q <= frac_next;
        last_q <= cnt_in;
      end

      if (gnt[OP_RATE]) begin
        mult_q <= mult_new;
        sat_q  <= sat_q | rate_clamped;
      end
    end
  end

  assign host_gnt   = gnt;
  assign cnt_clear  = gnt[OP_RST];
  assign snap_ns    = snap_q;
  assign snap_valid = snap_v_q;
  assign rate_mult  = mult_q;
  assign rate_sat   = sat_q;
endmodule

// File: rtl/tc_timecounter_chk.sv
module tc_timecounter_chk #(
  parameter int CNT_W  = 64,
  parameter int NS_W   = 64,
  parameter int MULT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cnt_in,
  input logic [4:0]        host_req,
  input logic [NS_W-1:0]   op_data,
  input logic [4:0]        host_gnt,
  input logic [NS_W-1:0]   now_ns,
  input logic [MULT_W-1:0] rate_mult,
  input logic              rate_sat,
  input logic              refresh_fire
);
  localparam logic [MULT_W-1:0] MULT_LO = MULT_W'(32'h7BE7_6C8C);
  localparam logic [MULT_W-1:0] MULT_HI = MULT_W'(32'h8418_9374);

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(host_gnt));

  assert_restart_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_req[4] |-> (host_gnt == 5'b10000));

  assert_snap_beats_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req[0] && !host_req[4]) |-> host_gnt[0]);

  assert_snap_keeps_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt[0] |=> (!$stable(cnt_in) || $stable(now_ns)));

  assert_load_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt[1] |=> (!$stable(cnt_in) || now_ns == $past(op_data)));

  assert_rate_folds_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt[3] |=> (!$stable(cnt_in) || $stable(now_ns)));

  assert_mult_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_mult >= MULT_LO) && (rate_mult <= MULT_HI));

  assert_sat_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rate_sat |=> rate_sat);

  assert_refresh_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_fire |-> (host_req == 5'b00000));

  assert_refresh_keeps_time_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_fire |=> (!$stable(cnt_in) || $stable(now_ns)));
endmodule

bind tc_timecounter tc_timecounter_chk #(.CNT_W(CNT_W), .NS_W(NS_W), .MULT_W(MULT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_in       (cnt_in),
  .host_req     (host_req),
  .op_data      (op_data),
  .host_gnt     (host_gnt),
  .now_ns       (now_ns),
  .rate_mult    (rate_mult),
  .rate_sat     (rate_sat),
  .refresh_fire (refresh_fire)
);

// File: tb/tc_timecounter_bench.sv
module tc_timecounter_bench;
  localparam longint unsigned LIM = 40;
  localparam logic [4:0] Q_IDLE = 5'b00000, Q_READ = 5'b00001, Q_SET = 5'b00010,
                         Q_ADJ = 5'b00100, Q_RATE = 5'b01000, Q_RST = 5'b10000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt_in = '0;
  logic [4:0]  host_req = '0;
  logic [63:0] op_data = '0;
  logic [4:0]  host_gnt;
  logic        cnt_clear;
  logic [63:0] now_ns, snap_ns;
  logic        snap_valid;
  logic [31:0] rate_mult;
  logic        rate_sat;
  logic        refresh_fire;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  tc_timecounter #(.REFRESH_CYCLES(LIM)) u_tc_timecounter (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .host_req(host_req), .op_data(op_data),
    .host_gnt(host_gnt), .cnt_clear(cnt_clear), .now_ns(now_ns), .snap_ns(snap_ns),
    .snap_valid(snap_valid), .rate_mult(rate_mult), .rate_sat(rate_sat),
    .refresh_fire(refresh_fire)
  );

  typedef struct packed {
    logic [4:0]  req;
    logic [63:0] cnt;
    logic [63:0] data;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{5'b00010, 64'd100,  64'd1000, 64'd0},
    '{5'b00001, 64'd110,  64'd0,    64'd1080},
    '{5'b00100, 64'd120,  64'd500,  64'd0},
    '{5'b00001, 64'd125,  64'd0,    64'd1700},
    '{5'b00100, 64'd125,  64'hFFFF_FFFF_FFFF_FD44, 64'd0},
    '{5'b00001, 64'd135,  64'd0,    64'd1080},
    '{5'b00010, 64'd1000, 64'd0,    64'd0},
    '{5'b00001, 64'd1000, 64'd0,    64'd0},
    '{5'b00001, 64'h1_0000_03E8, 64'd0, 64'h8_0000_0000},
    '{5'b00010, 64'hFFFF_FFFF_FFFF_FFFE, 64'd5, 64'd0},
    '{5'b00001, 64'd3,    64'd0,    64'd45},
    '{5'b00100, 64'd3,    64'd1_000_000_000_000, 64'd0},
    '{5'b00001, 64'd3,    64'd0,    64'd1_000_000_000_045}
  };

  // reference: time held as one fixed-point accumulator with 28 fraction bits
  logic [127:0] m_acc  = '0;
  logic [63:0]  m_last = '0;
  logic [31:0]  m_mult = 32'h8000_0000;
  logic         m_sat  = 1'b0;

  function automatic logic [63:0] m_now(input logic [63:0] c);
    logic [127:0] t;
    t = m_acc + {64'b0, c - m_last} * {96'b0, m_mult};
    return t[91:28];
  endfunction

  task automatic m_fold(input logic [63:0] c);
    m_acc  = m_acc + {64'b0, c - m_last} * {96'b0, m_mult};
    m_last = c;
  endtask

  task automatic m_rate(input logic [63:0] c, input logic [31:0] p);
    longint a, mag;
    bit neg;
    m_fold(c);
    a = longint'($signed(p));
    if (a > 64'sd2097152000) begin a = 64'sd2097152000; m_sat = 1'b1; end
    else if (a < -64'sd2097152000) begin a = -64'sd2097152000; m_sat = 1'b1; end
    neg = (a < 0);
    mag = neg ? -a : a;
    mag = (mag * 512) / 15625;
    m_mult = 32'(64'sh8000_0000 + (neg ? -mag : mag));
  endtask

  task automatic m_apply(input logic [4:0] r, input logic [63:0] c, input logic [63:0] d);
    if (r[4])      begin m_acc = {64'b0, d} << 28; m_last = '0; end
    else if (r[0]) m_fold(c);
    else if (r[1]) begin m_acc = {64'b0, d} << 28; m_last = c; end
    else if (r[2]) m_acc = m_acc + ({64'b0, d} << 28);
    else if (r[3]) m_rate(c, d[31:0]);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [4:0] r, input logic [63:0] c, input logic [63:0] d);
    @(negedge clk);
    host_req = r; cnt_in = c; op_data = d;
    @(posedge clk);
    #1 host_req = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic quiet;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset now_ns", now_ns, 64'd0);
    chk("R1 reset mult", {32'b0, rate_mult}, 64'h8000_0000);
    chk("R6 reset sat", {63'b0, rate_sat}, 64'd0);
    chk("R8 reset grant", {59'b0, host_gnt}, 64'd0);

    // table walk at nominal rate
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].req, VEC[i].cnt, VEC[i].data);
      m_apply(VEC[i].req, VEC[i].cnt, VEC[i].data);
      chk($sformatf("R1 vec%0d now", i), now_ns, m_now(VEC[i].cnt));
      if (VEC[i].req == Q_READ) begin
        chk($sformatf("R2 vec%0d snap", i), snap_ns, VEC[i].exp);
        chk($sformatf("R2 vec%0d strobe", i), {63'b0, snap_valid}, 64'd1);
      end
      if (VEC[i].req == Q_SET) chk($sformatf("R3 vec%0d load", i), now_ns, VEC[i].data);
      if (VEC[i].req == Q_ADJ) chk($sformatf("R4 vec%0d mult kept", i), {32'b0, rate_mult}, 64'h8000_0000);
    end
    @(negedge clk);
    chk("R2 strobe one cycle", {63'b0, snap_valid}, 64'd0);

    // R5 fold before rate change
    do_op(Q_SET, 64'd0, 64'd0);         m_apply(Q_SET, 64'd0, 64'd0);
    do_op(Q_RATE, 64'd100_000_000, 64'd1_562_500);
    m_apply(Q_RATE, 64'd100_000_000, 64'd1_562_500);
    chk("R5 mult +1562500", {32'b0, rate_mult}, 64'h8000_C800);
    chk("R5 fold at old rate", now_ns, 64'd800_000_000);
    do_op(Q_IDLE, 64'd200_000_000, 64'd0);
    chk("R5 new rate segment", now_ns, m_now(64'd200_000_000));
    chk("R5 new rate value", now_ns, 64'd1_600_019_073);
    do_op(Q_RATE, 64'd200_000_000, 64'hFFFF_FF9C);
    m_apply(Q_RATE, 64'd200_000_000, 64'hFFFF_FF9C);
    chk("R5 trunc toward zero -100", {32'b0, rate_mult}, 64'h7FFF_FFFD);
    do_op(Q_RATE, 64'd200_000_000, 64'd1);
    m_apply(Q_RATE, 64'd200_000_000, 64'd1);
    chk("R5 small ppm", {32'b0, rate_mult}, 64'h8000_0000);
    do_op(Q_RATE, 64'd200_000_000, 64'hFFFF_C2F7);
    m_apply(Q_RATE, 64'd200_000_000, 64'hFFFF_C2F7);
    chk("R5 ppm -15625", {32'b0, rate_mult}, 64'h7FFF_FE00);
    chk("R6 no clamp yet", {63'b0, rate_sat}, 64'd0);

    // R6 clamp high, R7 fraction carry
    do_op(Q_SET, 64'd500, 64'd0);        m_apply(Q_SET, 64'd500, 64'd0);
    do_op(Q_RATE, 64'd500, 64'h7FFF_FFFF); m_apply(Q_RATE, 64'd500, 64'h7FFF_FFFF);
    chk("R6 clamp high mult", {32'b0, rate_mult}, 64'h8418_9374);
    chk("R6 sat set", {63'b0, rate_sat}, {63'b0, m_sat});
    for (int k = 1; k <= 20; k++) begin
      do_op(Q_READ, 64'd500 + 64'(k), 64'd0);
      m_apply(Q_READ, 64'd500 + 64'(k), 64'd0);
    end
    chk("R7 carried fraction", snap_ns, 64'd165);
    chk("R7 model match", snap_ns, m_now(64'd520));
    do_op(Q_RATE, 64'd520, 64'h8000_0000); m_apply(Q_RATE, 64'd520, 64'h8000_0000);
    chk("R6 clamp low mult", {32'b0, rate_mult}, 64'h7BE7_6C8C);
    do_op(Q_RATE, 64'd520, 64'd0);        m_apply(Q_RATE, 64'd520, 64'd0);
    chk("R6 sat sticky", {63'b0, rate_sat}, 64'd1);
    chk("R5 back to nominal", {32'b0, rate_mult}, 64'h8000_0000);

    // R8 priority
    do_op(Q_SET, 64'd1000, 64'd0); m_apply(Q_SET, 64'd1000, 64'd0);
    @(negedge clk);
    host_req = Q_READ | Q_SET; op_data = 64'd999;
    #1 chk("R8 snapshot beats load", {59'b0, host_gnt}, {59'b0, Q_READ});
    @(posedge clk); #1 host_req = Q_SET;
    @(negedge clk);
    chk("R8 load next", {59'b0, host_gnt}, {59'b0, Q_SET});
    @(posedge clk); #1 host_req = '0;
    @(negedge clk);
    chk("R3 load after contention", now_ns, 64'd999);
    m_apply(Q_SET, 64'd1000, 64'd999);
    host_req = Q_ADJ | Q_RATE; op_data = 64'd0;
    #1 chk("R8 offset beats rate", {59'b0, host_gnt}, {59'b0, Q_ADJ});
    host_req = Q_RST | Q_READ; op_data = 64'd777;
    #1 chk("R8 restart beats snapshot", {59'b0, host_gnt}, {59'b0, Q_RST});
    chk("R9 clear with grant", {63'b0, cnt_clear}, 64'd1);
    @(posedge clk); #1 host_req = '0; cnt_in = '0;
    @(negedge clk);
    m_apply(Q_RST, 64'd0, 64'd777);
    chk("R9 restart time", now_ns, 64'd777);
    chk("R9 clear released", {63'b0, cnt_clear}, 64'd0);

    // R10 refresh timing
    do_op(Q_READ, 64'd50, 64'd0); m_apply(Q_READ, 64'd50, 64'd0);
    repeat (int'(LIM) - 1) @(negedge clk);
    chk("R10 not yet due", {63'b0, refresh_fire}, 64'd0);
    @(negedge clk);
    chk("R10 fires on time", {63'b0, refresh_fire}, 64'd1);
    @(negedge clk);
    chk("R10 time unchanged", now_ns, m_now(64'd50));
    chk("R10 timer restarted", {63'b0, refresh_fire}, 64'd0);

    // R10 refresh deferred behind held request
    do_op(Q_READ, 64'd60, 64'd0); m_apply(Q_READ, 64'd60, 64'd0);
    host_req = Q_ADJ; op_data = 64'd0;
    quiet = 1'b1;
    for (int k = 0; k < int'(LIM) + 20; k++) begin
      @(negedge clk);
      if (refresh_fire) quiet = 1'b0;
    end
    chk("R10 held off by request", {63'b0, quiet}, 64'd1);
    chk("R4 zero offset keeps time", now_ns, m_now(64'd60));
    host_req = '0;
    #1 chk("R10 fires when idle", {63'b0, refresh_fire}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 drops after fold", {63'b0, refresh_fire}, 64'd0);
    chk("R10 fold keeps time", now_ns, m_now(64'd60));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule